// File: doc/BRIEF.md
# Parallel Lane Memory Access Coalescer

A group of 32 parallel processing lanes each presents, in the same cycle, at most one 4-byte word read with its own byte address. The coalescer captures the whole group. It then folds the lane requests into the smallest set of aligned 128-byte line transactions. Each transaction names the line (byte address with the low 7 bits dropped) and carries a mask of the lanes it serves. Transactions leave one per handshake under valid/ready flow control. The lowest-numbered lane still waiting decides which line goes next.

Returned lines come back tagged with their line address, in any order. The block picks each served lane's word out of the line using address bits [6:2]. It delivers the words to every lane of that line in a single cycle. A new group is accepted only once every line of the current group has been returned. Lanes that are not valid take no part.

Top module: `memory_coalescer`

## Requirements
- R1: After reset `req_ready` is 1, `txn_valid` is 0 and `out_valid` is all zeros.
- R2: A group in which all 32 lanes read consecutive words of one aligned line produces exactly one transaction, whose mask has all 32 bits set.
- R3: A group produces exactly one transaction for each distinct line touched by its valid lanes, and `txn_line` equals lane address bits [31:7].
- R4: Transactions appear in increasing order of the lowest-numbered lane each serves, and one transaction is retired per cycle in which `txn_valid` and `txn_ready` are both 1. A transaction's mask holds every still-unserved valid lane whose line matches.
- R5: A lane whose `req_lane_vld` bit is 0 never appears in any transaction mask and never sees `out_valid`, whatever its address.
- R6: Several lanes reading the same word, or different words of one line, are all served by a single transaction.
- R7: While `txn_valid` is 1 and `txn_ready` is 0, the next cycle still shows `txn_valid` 1 with `txn_line` and `txn_mask` unchanged.
- R8: A cycle with `rsp_valid` 1 and `rsp_line` equal to an issued, not yet returned line raises, in the following cycle only, `out_valid` for exactly that transaction's lanes. Each such lane gets bits [32w+31:32w] of `rsp_data` on its 32-bit slice of `out_data`, where w is its address bits [6:2].
- R9: A response whose line matches no issued, unreturned line raises no `out_valid` and leaves the block's progress unchanged.
- R10: `req_ready` is 0 from the cycle after a group with at least one valid lane is accepted until the cycle after its last line returns. A group with no valid lanes produces no transaction and leaves `req_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | Block is idle and takes a group |
| req_lane_vld | input | 32 | Per-lane request valid |
| req_addr | input | 1024 | Per-lane byte address, lane i at bits [32i+31:32i]; bits [1:0] disregarded |
| txn_valid | output | 1 | A line transaction is offered |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_line | output | 25 | Line address (byte address bits [31:7]) |
| txn_mask | output | 32 | Lanes served by this transaction |
| rsp_valid | input | 1 | Line data is returned |
| rsp_line | input | 25 | Line address of the returned data |
| rsp_data | input | 1024 | Returned line, word w at bits [32w+31:32w] |
| out_valid | output | 32 | Per-lane delivery strobe |
| out_data | output | 1024 | Per-lane delivered word, lane i at bits [32i+31:32i] |

## Verification
The bench goes after the merge boundaries:
- a fully contiguous group, where a merge that is too fine yields more than one fetch;
- 32 lanes on 32 lines, where a merge that is too coarse drops a line;
- all lanes on one word, where a design that dedups lanes starves some of them;
- groups with masked-off lanes placed on foreign lines, where a design that ignores the valid bit issues extra fetches or delivers spurious data.

Ordering is checked with lane-to-line maps that put a later line under a lower lane. Responses come back in reverse order, so routing by issue order instead of by line address sends words to the wrong lanes. Stalls, stray responses and an empty group probe the flow control. A single-lane sweep over every lane catches lane-indexing slips.

// File: rtl/coal_pkg.sv
// Package: shared defaults and the occupancy state of the coalescer.
// Assumes byte addressing, power-of-two word and line sizes.
package coal_pkg;
    localparam int LANES_DEF      = 32;
    localparam int ADDR_W_DEF     = 32;
    localparam int WORD_BYTES_DEF = 4;
    localparam int LINE_BYTES_DEF = 128;

    // Occupancy of the current request group.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no group held
        ST_ISSUE = 2'd1,   // lanes still waiting for a transaction
        ST_DRAIN = 2'd2    // all issued, lines still outstanding
    } coal_state_e;
endpackage

// File: rtl/coal_prio.sv
// coal_prio: finds the lowest set bit of a request vector.
// Assumes N >= 2; idx is meaningless when found is 0.
module coal_prio #(
    parameter int N     = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/coal_line_match.sv
// coal_line_match: per-lane compare of a stored line address with a key.
// Assumes lane lines are packed lane 0 at the bottom.
module coal_line_match #(
    parameter int N   = 32,
    parameter int LAW = 25
) (
    input  logic [N*LAW-1:0] lane_line,
    input  logic [LAW-1:0]   key,
    input  logic [N-1:0]     en,
    output logic [N-1:0]     hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        // One comparator per lane, gated by its enable.
        assign hit[g] = en[g] && (lane_line[g*LAW +: LAW] == key);
    end
endmodule

// File: rtl/coal_scatter.sv
// coal_scatter: registers the word each firing lane selects from a line.
// Assumes fire lanes already match the returned line; holds data otherwise.
module coal_scatter #(
    parameter int N      = 32,
    parameter int OFF_W  = 5,
    parameter int WORD_W = 32,
    localparam int WPL   = 1 << OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        fire,
    input  logic [N*OFF_W-1:0]  lane_off,
    input  logic [WPL*WORD_W-1:0] line_data,
    output logic [N-1:0]        out_valid,
    output logic [N*WORD_W-1:0] out_data
);
    // One-cycle strobe for each lane served by the returned line.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= '0;
        else        out_valid <= fire;
    end

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [OFF_W-1:0] off;
        assign off = lane_off[g*OFF_W +: OFF_W];
        // Capture this lane's word when its line comes back.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_data[g*WORD_W +: WORD_W] <= '0;
            else if (fire[g])
                out_data[g*WORD_W +: WORD_W] <= line_data[off*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/memory_coalescer.sv
// memory_coalescer: merges per-lane word reads into aligned line transactions
// and scatters returned lines back to the lanes.
// Assumes: one group in flight; responses tagged by line, any order; each
// issued line returns exactly once; address bits below the word are ignored.
module memory_coalescer #(
    parameter int LANES      = coal_pkg::LANES_DEF,
    parameter int ADDR_W     = coal_pkg::ADDR_W_DEF,
    parameter int WORD_BYTES = coal_pkg::WORD_BYTES_DEF,
    parameter int LINE_BYTES = coal_pkg::LINE_BYTES_DEF,
    localparam int WORD_W    = WORD_BYTES * 8,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BYTE_SH   = $clog2(WORD_BYTES),
    localparam int LINE_SH   = $clog2(LINE_BYTES),
    localparam int OFF_W     = LINE_SH - BYTE_SH,
    localparam int LAW       = ADDR_W - LINE_SH,
    localparam int IDX_W     = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_lane_vld,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [LAW-1:0]          txn_line,
    output logic [LANES-1:0]        txn_mask,
    input  logic                    rsp_valid,
    input  logic [LAW-1:0]          rsp_line,
    input  logic [LINE_W-1:0]       rsp_data,
    output logic [LANES-1:0]        out_valid,
    output logic [LANES*WORD_W-1:0] out_data
);
    import coal_pkg::*;

    // Group storage
    logic [LANES*LAW-1:0]   lane_line_q, lane_line_d;
    logic [LANES*OFF_W-1:0] lane_off_q,  lane_off_d;
    logic [LANES-1:0]       grp_vld_q;
    logic [LANES-1:0]       pend_q;      // valid lanes not yet in a transaction
    logic [LANES-1:0]       wait_q;      // issued lanes whose line has not returned
    logic [LANES*BYTE_SH-1:0] unused_lsb;

    coal_state_e state;
    logic        accept, txn_fire;
    logic        lead_found;
    logic [IDX_W-1:0] lead_idx;
    logic [LANES-1:0] issue_hit, rsp_hit, fire;

    // Split each lane address into line and word offset.
    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_line_d[g*LAW +: LAW] =
            req_addr[g*ADDR_W + LINE_SH +: LAW];
        assign lane_off_d[g*OFF_W +: OFF_W] =
            req_addr[g*ADDR_W + BYTE_SH +: OFF_W];
        assign unused_lsb[g*BYTE_SH +: BYTE_SH] =
            req_addr[g*ADDR_W +: BYTE_SH];
    end

    // Occupancy decode from the two lane sets.
    always_comb begin
        if (|pend_q)      state = ST_ISSUE;
        else if (|wait_q) state = ST_DRAIN;
        else              state = ST_IDLE;
    end

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Leading lane of the next transaction.
    coal_prio #(.N(LANES)) u_lead (
        .req   (pend_q),
        .found (lead_found),
        .idx   (lead_idx)
    );

    assign txn_line = lane_line_q[lead_idx*LAW +: LAW];

    // Every pending lane on the leading lane's line joins the transaction.
    coal_line_match #(.N(LANES), .LAW(LAW)) u_issue_match (
        .lane_line (lane_line_q),
        .key       (txn_line),
        .en        (pend_q),
        .hit       (issue_hit)
    );

    assign txn_valid = lead_found;
    assign txn_mask  = issue_hit;
    assign txn_fire  = txn_valid && txn_ready;

    // Waiting lanes on the returned line are served.
    coal_line_match #(.N(LANES), .LAW(LAW)) u_rsp_match (
        .lane_line (lane_line_q),
        .key       (rsp_line),
        .en        (wait_q),
        .hit       (rsp_hit)
    );

    assign fire = rsp_valid ? rsp_hit : '0;

    // Capture lane addresses and valid bits at group acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_line_q <= '0;
            lane_off_q  <= '0;
            grp_vld_q   <= '0;
        end else if (accept) begin
            lane_line_q <= lane_line_d;
            lane_off_q  <= lane_off_d;
            grp_vld_q   <= req_lane_vld;
        end
    end

    // Move lanes from pending to waiting on issue, drop them on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            wait_q <= '0;
        end else if (accept) begin
            pend_q <= req_lane_vld;
            wait_q <= '0;
        end else begin
            pend_q <= txn_fire ? (pend_q & ~txn_mask) : pend_q;
            wait_q <= (wait_q | (txn_fire ? txn_mask : '0)) & ~fire;
        end
    end

    // Word selection and delivery.
    coal_scatter #(.N(LANES), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_scatter (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .lane_off  (lane_off_q),
        .line_data (rsp_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/memory_coalescer_checker.sv
// memory_coalescer_checker: protocol and merge-order properties of the coalescer.
// Assumes it is bound into memory_coalescer with access to its lane sets.
module memory_coalescer_checker #(
    parameter int LANES = 32,
    parameter int LAW   = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             txn_valid,
    input logic             txn_ready,
    input logic [LAW-1:0]   txn_line,
    input logic [LANES-1:0] txn_mask,
    input logic             rsp_valid,
    input logic [LANES-1:0] out_valid,
    input logic [LANES-1:0] pend_q,
    input logic [LANES-1:0] grp_vld_q
);
    localparam logic [LANES-1:0] ONE = 1;

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_mask)));

    a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> !req_ready);

    a_r5_mask_in_group: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask & ~grp_vld_q) == '0));

    a_r4_lowest_lane_leads: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask & (~txn_mask + ONE)) == (pend_q & (~pend_q + ONE))));

    a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_mask != '0));

    a_r8_out_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> $past(rsp_valid));
endmodule

bind memory_coalescer memory_coalescer_checker #(.LANES(LANES), .LAW(LAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_line  (txn_line),
    .txn_mask  (txn_mask),
    .rsp_valid (rsp_valid),
    .out_valid (out_valid),
    .pend_q    (pend_q),
    .grp_vld_q (grp_vld_q)
);

// File: tb/tb_memory_coalescer.sv
`timescale 1ns/1ps
module tb_memory_coalescer;
    localparam int N   = 32;
    localparam int AW  = 32;
    localparam int LAW = 25;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n;
    logic              req_valid, req_ready;
    logic [N-1:0]      req_lane_vld;
    logic [N*AW-1:0]   req_addr;
    logic              txn_valid, txn_ready;
    logic [LAW-1:0]    txn_line;
    logic [N-1:0]      txn_mask;
    logic              rsp_valid;
    logic [LAW-1:0]    rsp_line;
    logic [1023:0]     rsp_data;
    logic [N-1:0]      out_valid;
    logic [N*32-1:0]   out_data;

    memory_coalescer dut (.*);

    int checks = 0, fails = 0;
    bit done = 0;

    logic [AW-1:0]  a  [N];
    logic [N-1:0]   v;
    logic [LAW-1:0] el [N];
    logic [N-1:0]   em [N];
    int ne;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [LAW-1:0] l, input int w);
        return (32'(l) * 32'h9E3779B1) ^ (32'(w) * 32'h01000193);
    endfunction

    task automatic fill_line(input logic [LAW-1:0] l);
        for (int w = 0; w < 32; w++) rsp_data[w*32 +: 32] = pat(l, w);
    endtask

    // Expected transactions: walk lanes upward, each uncovered valid lane opens a line.
    task automatic build_exp();
        logic [N-1:0] cov, m;
        cov = '0;
        ne = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i] && !cov[i]) begin
                el[ne] = a[i][31:7];
                m = '0;
                for (int j = 0; j < N; j++)
                    if (v[j] && a[j][31:7] == el[ne]) m[j] = 1'b1;
                em[ne] = m;
                cov |= m;
                ne++;
            end
        end
    endtask

    task automatic run_group(input string tag, input bit bp, input bit stray);
        build_exp();
        @(negedge clk);
        req_valid    = 1'b1;
        req_lane_vld = v;
        for (int i = 0; i < N; i++) req_addr[i*AW +: AW] = a[i];
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == (ne == 0), "R10", "ready after accept", 64'(req_ready), 64'(ne == 0));
        for (int k = 0; k < ne; k++) begin
            if (bp && (k % 5 == 0)) begin
                txn_ready = 1'b0;
                repeat (2) @(negedge clk);
                chk(txn_valid && txn_line == el[k] && txn_mask == em[k], "R7",
                    "held under stall", 64'(txn_mask), 64'(em[k]));
            end
            chk(txn_valid == 1'b1, "R4", "txn offered", 64'(txn_valid), 64'd1);
            chk(txn_line == el[k], "R3", "txn line", 64'(txn_line), 64'(el[k]));
            chk(txn_mask == em[k], tag, "txn mask order", 64'(txn_mask), 64'(em[k]));
            txn_ready = 1'b1;
            @(negedge clk);
            txn_ready = 1'b0;
        end
        chk(txn_valid == 1'b0, "R3", "no extra txn", 64'(txn_valid), 64'd0);
        if (stray) begin
            rsp_valid = 1'b1;
            rsp_line  = 25'h1ABCDE;
            fill_line(rsp_line);
            @(negedge clk);
            rsp_valid = 1'b0;
            chk(out_valid == '0, "R9", "stray rsp delivers", 64'(out_valid), 64'd0);
            chk(req_ready == (ne == 0), "R9", "stray rsp releases", 64'(req_ready), 64'(ne == 0));
        end
        for (int k = ne - 1; k >= 0; k--) begin
            rsp_valid = 1'b1;
            rsp_line  = el[k];
            fill_line(el[k]);
            @(negedge clk);
            rsp_valid = 1'b0;
            chk(out_valid == em[k], tag, "out_valid set", 64'(out_valid), 64'(em[k]));
            for (int i = 0; i < N; i++)
                if (em[k][i])
                    chk(out_data[i*32 +: 32] == pat(el[k], int'(a[i][6:2])), "R8",
                        "lane word", 64'(out_data[i*32 +: 32]), 64'(pat(el[k], int'(a[i][6:2]))));
            chk(req_ready == (k == 0), "R10", "ready vs outstanding", 64'(req_ready), 64'(k == 0));
        end
        @(negedge clk);
        chk(out_valid == '0, "R8", "strobe one cycle", 64'(out_valid), 64'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_lane_vld = '0; req_addr = '0;
        txn_ready = 1'b0; rsp_valid = 1'b0; rsp_line = '0; rsp_data = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !txn_valid && out_valid == '0, "R1", "in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready", 64'(req_ready), 64'd1);
        chk(txn_valid == 1'b0, "R1", "txn idle", 64'(txn_valid), 64'd0);
        chk(out_valid == '0, "R1", "out idle", 64'(out_valid), 64'd0);

        // R2: contiguous aligned line
        v = '1;
        for (int i = 0; i < N; i++) a[i] = 32'h1000 + 32'(i * 4);
        run_group("R2", 1'b0, 1'b0);
        chk(ne == 1, "R2", "bench expects one", 64'(ne), 64'd1);

        // R3: every lane on its own line
        for (int i = 0; i < N; i++) a[i] = 32'h4000 + 32'(i * 128) + 32'(((i * 3) % 32) * 4);
        run_group("R3", 1'b1, 1'b0);

        // R6: all lanes on one word
        for (int i = 0; i < N; i++) a[i] = 32'h8014;
        run_group("R6", 1'b0, 1'b0);

        // R5: masked lanes parked on foreign lines
        v = 32'h0F0F_33F0;
        for (int i = 0; i < N; i++)
            a[i] = v[i] ? 32'hC000 + 32'(((31 - i) % 3) * 128) + 32'(i * 4)
                        : 32'hF000 + 32'(i * 128);
        run_group("R5", 1'b0, 1'b1);

        // R4: later lines under lower lanes, stalls in between
        v = '1;
        for (int i = 0; i < N; i++)
            a[i] = 32'h10000 + 32'(((i * 7) % 5) * 128) + 32'((31 - i) * 4);
        run_group("R4", 1'b1, 1'b1);

        // R10: empty group
        v = '0;
        run_group("R10", 1'b0, 1'b0);
        chk(req_ready == 1'b1, "R10", "empty group idle", 64'(req_ready), 64'd1);

        // R9: stray response while idle
        @(negedge clk);
        rsp_valid = 1'b1; rsp_line = 25'h0040; fill_line(rsp_line);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(out_valid == '0, "R9", "idle stray", 64'(out_valid), 64'd0);

        // R5: single valid lane sweep over every lane
        for (int s = 0; s < N; s++) begin
            v = '0; v[s] = 1'b1;
            for (int i = 0; i < N; i++) a[i] = 32'h20000 + 32'(((i + s) % 4) * 128) + 32'(s * 4);
            run_group("R5", 1'b0, 1'b0);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule